// File: doc/BRIEF.md
# Self-Checking Card Access Controller

This block is the control state machine of a card-and-PIN access terminal. It accepts single-cycle strobes for card insertion, cancel, PIN validation, end of banking operations and card removal. It also takes the code stored on the card and the code the user typed. From these it decides each cycle whether to eject the card, retain it, or let banking operations start.

The block keeps three data registers: an attempt counter, the expected (card) code and the entered code. Each register is held twice, as a working copy and a shadow copy, and flags an error when the two differ. Any flagged error stops access from being granted and pushes the machine towards ejecting the card.

A test-only injection port flips bits in the working copy of one chosen register. Verification uses it to show that corruption is always detected and never leads to access. All outputs are Mealy functions of the current state, the register contents and the current inputs.

Top module: `card_access_ctl`

## Requirements
- R1: While reset is low, and in the first cycle after it, the machine is idle and all four outputs are low.
- R2: In idle, an insert strobe moves to card-present, loads the attempt counter with 1 and captures the card code as the expected code; without the strobe the machine stays idle.
- R3: In card-present, cancel or a register error asserts eject in that cycle and moves to card-out. Otherwise, validate moves to code-test and captures the user code as the entered code.
- R4: In code-test with equal codes and no register error, start-operations is asserted in that cycle and the machine moves to granted.
- R5: In code-test with unequal codes and a counter value below 3, the counter increments, no output is asserted and the machine returns to card-present.
- R6: In code-test with unequal codes, a counter value of 3 or more and no error, retain is asserted and the machine moves to a code-error state. The next cycle clears both code registers and returns to idle.
- R7: In granted, start-operations stays high while cancel and ops-done are low and there is no error. Cancel, ops-done or an error asserts eject instead and moves to card-out.
- R8: Card-out holds until the card-taken strobe. That strobe clears both code registers and returns to idle.
- R9: The error output is the OR of the three per-register copy mismatches, and it never rises without an injection.
- R10: An injection with a nonzero mask on register select 0 (counter, low bits of the mask), 1 (expected code) or 2 (entered code) raises the error output from the next cycle. The error stays high until that register is loaded again. A zero mask or select 3 has no effect.
- R11: While the error output is high, neither start-operations nor retain is asserted, and eject is forced in card-present, code-test and granted.
- R12: A validate strobe together with cancel in card-present does not load the entered code, and the machine moves to card-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_insert_i | input | 1 | Card inserted strobe |
| cancel_i | input | 1 | Cancel button |
| validate_i | input | 1 | PIN entry validated |
| ops_done_i | input | 1 | Banking operations finished |
| card_taken_i | input | 1 | Card removed by user |
| card_code_i | input | CODE_W | Code read from the card |
| user_code_i | input | CODE_W | Code typed by the user |
| inj_valid_i | input | 1 | Test-only fault injection enable |
| inj_sel_i | input | 2 | Injection target: 0 counter, 1 expected, 2 entered, 3 none |
| inj_mask_i | input | CODE_W | Bits to flip in the working copy |
| eject_o | output | 1 | Eject the card |
| retain_o | output | 1 | Keep the card |
| start_ops_o | output | 1 | Banking operations may start |
| err_o | output | 1 | Register corruption detected |

## Verification
Eject, retain and start-operations depend on the present state and inputs in the same cycle, so the bench applies each stimulus just after a falling edge and compares all four outputs one time unit later, before the rising edge. The effects of a transition, a register load or an injection appear only after the next rising edge. The bench reference model therefore commits its next state at that edge and compares again in the following cycle, where an injection shows up first on the error output.

// File: rtl/card_ctl_pkg.sv
package card_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_PRESENT  = 3'd1,
      ST_TEST     = 3'd2,
      ST_CODE_ERR = 3'd3,
      ST_GRANTED  = 3'd4,
      ST_OUT      = 3'd5
   } cc_state_e;

   localparam int SEL_CNT = 0;
   localparam int SEL_EXP = 1;
   localparam int SEL_ENT = 2;
   localparam int NUM_REGS = 3;

endpackage

// File: rtl/dup_reg.sv
module dup_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] d_i,
   input  logic         flip_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] q_o,
   output logic         err_o
);

   logic [W-1:0] work_q;
   logic [W-1:0] shadow_q;
   logic [W-1:0] work_nxt;
   logic [W-1:0] flip_bits;

   generate
      if (W < 1) begin : g_bad_w
         $error("dup_reg: W must be at least 1");
      end
   endgenerate

   assign flip_bits = flip_i ? mask_i : '0;
   assign work_nxt  = (ld_i ? d_i : work_q) ^ flip_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q   <= '0;
         shadow_q <= '0;
      end else begin
         work_q <= work_nxt;
         if (ld_i) shadow_q <= d_i;
      end
   end

   assign q_o   = work_q;
   assign err_o = (work_q != shadow_q);

   // R9: without injection, a clean register stays clean
   p_clean_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flip_i && !err_o) |=> !err_o);

   // R10: a nonzero flip is always detected one cycle later
   p_flip_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flip_i && (mask_i != '0)) |=> err_o);

   // R10: a load without flip repairs the register
   p_reload_heals_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i && !flip_i) |=> !err_o);

endmodule

// File: rtl/card_ctl_next.sv
module card_ctl_next
   import card_ctl_pkg::*;
#(
   parameter int CODE_W  = 16,
   parameter int CNT_W   = 2,
   parameter int MAX_TRY = 3
) (
   input  cc_state_e             state_i,
   input  logic                  insert_i,
   input  logic                  cancel_i,
   input  logic                  validate_i,
   input  logic                  done_i,
   input  logic                  taken_i,
   input  logic [CODE_W-1:0]     card_code_i,
   input  logic [CODE_W-1:0]     user_code_i,
   input  logic [CNT_W-1:0]      cnt_q_i,
   input  logic                  match_i,
   input  logic                  err_i,
   output cc_state_e             state_nxt_o,
   output logic                  cnt_ld_o,
   output logic [CNT_W-1:0]      cnt_d_o,
   output logic                  exp_ld_o,
   output logic [CODE_W-1:0]     exp_d_o,
   output logic                  ent_ld_o,
   output logic [CODE_W-1:0]     ent_d_o
);

   localparam logic [CNT_W-1:0] TRY_LIM = CNT_W'(MAX_TRY);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic below_lim;
   assign below_lim = (cnt_q_i < TRY_LIM);

   always_comb begin
      state_nxt_o = state_i;
      cnt_ld_o    = 1'b0;
      cnt_d_o     = cnt_q_i;
      exp_ld_o    = 1'b0;
      exp_d_o     = '0;
      ent_ld_o    = 1'b0;
      ent_d_o     = '0;
      unique case (state_i)
         ST_IDLE: begin
            if (insert_i) begin
               state_nxt_o = ST_PRESENT;
               cnt_ld_o    = 1'b1;
               cnt_d_o     = CNT_ONE;
               exp_ld_o    = 1'b1;
               exp_d_o     = card_code_i;
            end
         end
         ST_PRESENT: begin
            if (validate_i && !cancel_i) begin
               ent_ld_o = 1'b1;
               ent_d_o  = user_code_i;
            end
            if (cancel_i || err_i)  state_nxt_o = ST_OUT;
            else if (validate_i)    state_nxt_o = ST_TEST;
         end
         ST_TEST: begin
            if (!match_i && below_lim) begin
               cnt_ld_o = 1'b1;
               cnt_d_o  = cnt_q_i + CNT_ONE;
            end
            if (err_i)          state_nxt_o = ST_OUT;
            else if (match_i)   state_nxt_o = ST_GRANTED;
            else if (below_lim) state_nxt_o = ST_PRESENT;
            else                state_nxt_o = ST_CODE_ERR;
         end
         ST_CODE_ERR: begin
            exp_ld_o    = 1'b1;
            ent_ld_o    = 1'b1;
            state_nxt_o = ST_IDLE;
         end
         ST_GRANTED: begin
            if (cancel_i || done_i || err_i) state_nxt_o = ST_OUT;
         end
         ST_OUT: begin
            if (taken_i) begin
               exp_ld_o    = 1'b1;
               ent_ld_o    = 1'b1;
               state_nxt_o = ST_IDLE;
            end
         end
         default: state_nxt_o = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/card_ctl_out.sv
module card_ctl_out
   import card_ctl_pkg::*;
#(
   parameter int CNT_W   = 2,
   parameter int MAX_TRY = 3
) (
   input  cc_state_e        state_i,
   input  logic             cancel_i,
   input  logic             done_i,
   input  logic [CNT_W-1:0] cnt_q_i,
   input  logic             match_i,
   input  logic             err_i,
   output logic             eject_o,
   output logic             retain_o,
   output logic             start_o
);

   localparam logic [CNT_W-1:0] TRY_LIM = CNT_W'(MAX_TRY);

   logic in_test, in_present, in_granted;
   assign in_test    = (state_i == ST_TEST);
   assign in_present = (state_i == ST_PRESENT);
   assign in_granted = (state_i == ST_GRANTED);

   assign start_o  = !err_i && ((in_test && match_i) ||
                                (in_granted && !cancel_i && !done_i));
   assign retain_o = in_test && !match_i && (cnt_q_i >= TRY_LIM) && !err_i;
   assign eject_o  = (in_granted && (cancel_i || done_i || err_i)) ||
                     (in_present && (cancel_i || err_i)) ||
                     (in_test && err_i);

endmodule

// File: rtl/card_access_ctl.sv
module card_access_ctl
   import card_ctl_pkg::*;
#(
   parameter int CODE_W  = 16,
   parameter int CNT_W   = 2,
   parameter int MAX_TRY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              card_insert_i,
   input  logic              cancel_i,
   input  logic              validate_i,
   input  logic              ops_done_i,
   input  logic              card_taken_i,
   input  logic [CODE_W-1:0] card_code_i,
   input  logic [CODE_W-1:0] user_code_i,
   input  logic              inj_valid_i,
   input  logic [1:0]        inj_sel_i,
   input  logic [CODE_W-1:0] inj_mask_i,
   output logic              eject_o,
   output logic              retain_o,
   output logic              start_ops_o,
   output logic              err_o
);

   localparam int NUM_CODE = 2;

   generate
      if (MAX_TRY < 1 || MAX_TRY > (1 << CNT_W) - 1) begin : g_bad_try
         $error("card_access_ctl: MAX_TRY must fit in CNT_W bits and be >= 1");
      end
      if (CNT_W > CODE_W) begin : g_bad_cnt
         $error("card_access_ctl: CNT_W must not exceed CODE_W");
      end
   endgenerate

   cc_state_e state_q, state_nxt;

   logic [NUM_REGS-1:0]              flip;
   logic [NUM_REGS-1:0]              reg_err;
   logic                             cnt_ld;
   logic [CNT_W-1:0]                 cnt_d, cnt_q;
   logic [NUM_CODE-1:0]              code_ld;
   logic [NUM_CODE-1:0][CODE_W-1:0]  code_d, code_q;
   logic                             match, err_any;

   always_comb begin
      flip = '0;
      if (inj_valid_i && (int'(inj_sel_i) < NUM_REGS)) flip[inj_sel_i] = 1'b1;
   end

   dup_reg #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_i   (cnt_ld),
      .d_i    (cnt_d),
      .flip_i (flip[SEL_CNT]),
      .mask_i (inj_mask_i[CNT_W-1:0]),
      .q_o    (cnt_q),
      .err_o  (reg_err[SEL_CNT])
   );

   for (genvar g = 0; g < NUM_CODE; g++) begin : g_code
      dup_reg #(.W(CODE_W)) u_code (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld_i   (code_ld[g]),
         .d_i    (code_d[g]),
         .flip_i (flip[SEL_EXP + g]),
         .mask_i (inj_mask_i),
         .q_o    (code_q[g]),
         .err_o  (reg_err[SEL_EXP + g])
      );
   end

   assign match   = (code_q[0] == code_q[1]);
   assign err_any = |reg_err;
   assign err_o   = err_any;

   card_ctl_next #(.CODE_W(CODE_W), .CNT_W(CNT_W), .MAX_TRY(MAX_TRY)) u_next (
      .state_i     (state_q),
      .insert_i    (card_insert_i),
      .cancel_i    (cancel_i),
      .validate_i  (validate_i),
      .done_i      (ops_done_i),
      .taken_i     (card_taken_i),
      .card_code_i (card_code_i),
      .user_code_i (user_code_i),
      .cnt_q_i     (cnt_q),
      .match_i     (match),
      .err_i       (err_any),
      .state_nxt_o (state_nxt),
      .cnt_ld_o    (cnt_ld),
      .cnt_d_o     (cnt_d),
      .exp_ld_o    (code_ld[0]),
      .exp_d_o     (code_d[0]),
      .ent_ld_o    (code_ld[1]),
      .ent_d_o     (code_d[1])
   );

   card_ctl_out #(.CNT_W(CNT_W), .MAX_TRY(MAX_TRY)) u_out (
      .state_i  (state_q),
      .cancel_i (cancel_i),
      .done_i   (ops_done_i),
      .cnt_q_i  (cnt_q),
      .match_i  (match),
      .err_i    (err_any),
      .eject_o  (eject_o),
      .retain_o (retain_o),
      .start_o  (start_ops_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_nxt;
   end

   // R11: an error blocks access and card retention
   p_err_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!start_ops_o && !retain_o));

   // R6: code-error state always falls back to idle
   p_codeerr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CODE_ERR) |=> (state_q == ST_IDLE));

   // R8: card-out holds until the card is taken
   p_out_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_OUT) && !card_taken_i) |=> (state_q == ST_OUT));

   // R4: granting access and ejecting never coincide
   p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_ops_o, eject_o, retain_o}));

   // R3: a cancel in card-present always leads to card-out
   p_cancel_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_PRESENT) && cancel_i) |=> (state_q == ST_OUT));

endmodule

// File: tb/tb_card_access_ctl.sv
module tb_card_access_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        card_insert_i = 0, cancel_i = 0, validate_i = 0;
   logic        ops_done_i = 0, card_taken_i = 0, inj_valid_i = 0;
   logic [15:0] card_code_i = '0, user_code_i = '0, inj_mask_i = '0;
   logic [1:0]  inj_sel_i = '0;
   logic        eject_o, retain_o, start_ops_o, err_o;

   int total = 0;
   int bad   = 0;

   // reference model state: 0 idle,1 present,2 test,3 code error,4 granted,5 out
   int          m_st = 0;
   logic [1:0]  m_cw = '0, m_cs = '0;
   logic [15:0] m_ew = '0, m_es = '0, m_nw = '0, m_ns = '0;

   always #5 clk = ~clk;

   card_access_ctl dut (
      .clk(clk), .rst_n(rst_n), .card_insert_i(card_insert_i),
      .cancel_i(cancel_i), .validate_i(validate_i), .ops_done_i(ops_done_i),
      .card_taken_i(card_taken_i), .card_code_i(card_code_i),
      .user_code_i(user_code_i), .inj_valid_i(inj_valid_i),
      .inj_sel_i(inj_sel_i), .inj_mask_i(inj_mask_i), .eject_o(eject_o),
      .retain_o(retain_o), .start_ops_o(start_ops_o), .err_o(err_o)
   );

   task automatic chk(string tag, string what, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one cycle: drive at falling edge, check outputs before rising edge, advance model
   task automatic cyc(string tag, bit ins, bit can, bit val, bit dn, bit tk,
                      logic [15:0] cc, logic [15:0] uc,
                      bit inj, int sel, logic [15:0] mk);
      bit e, mt, ex_start, ex_ret, ex_ej;
      int nst;
      logic [1:0]  ncw, ncs;
      logic [15:0] new_, nes, nnw, nns;
      card_insert_i = ins; cancel_i = can; validate_i = val;
      ops_done_i = dn; card_taken_i = tk; card_code_i = cc; user_code_i = uc;
      inj_valid_i = inj; inj_sel_i = 2'(sel); inj_mask_i = mk;
      #1;
      e  = (m_cw != m_cs) || (m_ew != m_es) || (m_nw != m_ns);
      mt = (m_ew == m_nw);
      ex_start = !e && ((m_st == 2 && mt) || (m_st == 4 && !can && !dn));
      ex_ret   = !e && m_st == 2 && !mt && m_cw >= 2'd3;
      ex_ej    = (m_st == 4 && (can || dn || e)) || (m_st == 1 && (can || e)) ||
                 (m_st == 2 && e);
      chk(tag, "err_o", err_o, e);
      chk(tag, "start_ops_o", start_ops_o, ex_start);
      chk(tag, "retain_o", retain_o, ex_ret);
      chk(tag, "eject_o", eject_o, ex_ej);
      nst = m_st; ncw = m_cw; ncs = m_cs; new_ = m_ew; nes = m_es; nnw = m_nw; nns = m_ns;
      case (m_st)
         0: if (ins) begin nst = 1; ncw = 2'd1; ncs = 2'd1; new_ = cc; nes = cc; end
         1: begin
            if (val && !can) begin nnw = uc; nns = uc; end
            if (can || e) nst = 5; else if (val) nst = 2;
         end
         2: begin
            if (!mt && m_cw < 2'd3) begin ncw = m_cw + 2'd1; ncs = m_cw + 2'd1; end
            if (e) nst = 5; else if (mt) nst = 4; else if (m_cw < 2'd3) nst = 1; else nst = 3;
         end
         3: begin nst = 0; new_ = '0; nes = '0; nnw = '0; nns = '0; end
         4: if (can || dn || e) nst = 5;
         default: if (tk) begin nst = 0; new_ = '0; nes = '0; nnw = '0; nns = '0; end
      endcase
      if (inj) begin
         if (sel == 0) ncw = ncw ^ mk[1:0];
         else if (sel == 1) new_ = new_ ^ mk;
         else if (sel == 2) nnw = nnw ^ mk;
      end
      @(posedge clk);
      m_st = nst; m_cw = ncw; m_cs = ncs; m_ew = new_; m_es = nes; m_nw = nnw; m_ns = nns;
      @(negedge clk);
   endtask

   task automatic quiet(string tag, int n);
      for (int i = 0; i < n; i++) cyc(tag, 0,0,0,0,0, '0,'0, 0,0,'0);
   endtask

   task automatic insert(string tag, logic [15:0] cc);
      cyc(tag, 1,0,0,0,0, cc,'0, 0,0,'0);
   endtask

   task automatic enter(string tag, logic [15:0] uc);
      cyc(tag, 0,0,1,0,0, '0,uc, 0,0,'0);
   endtask

   task automatic take(string tag);
      cyc(tag, 0,0,0,0,1, '0,'0, 0,0,'0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: outputs low during reset
      repeat (3) @(negedge clk);
      chk("R1", "eject_o", eject_o, 1'b0);
      chk("R1", "retain_o", retain_o, 1'b0);
      chk("R1", "start_ops_o", start_ops_o, 1'b0);
      chk("R1", "err_o", err_o, 1'b0);
      rst_n = 1'b1;
      quiet("R1", 2);

      // R2, R3, R4, R7, R8, R9: successful session ending on ops-done
      insert("R2", 16'h1234);
      quiet("R2", 2);
      enter("R3", 16'h1234);
      quiet("R4", 1);
      quiet("R7", 3);
      cyc("R7", 0,0,0,1,0, '0,'0, 0,0,'0);
      quiet("R8", 3);
      take("R8");
      quiet("R9", 2);

      // R5, R6: three wrong codes keep the card
      insert("R5", 16'hBEEF);
      enter("R5", 16'h0001);
      quiet("R5", 1);
      enter("R5", 16'h0002);
      quiet("R5", 1);
      enter("R6", 16'h0003);
      quiet("R6", 1);
      quiet("R6", 3);

      // R5: one wrong code then the right one, session cancelled in granted
      insert("R5", 16'hA5A5);
      enter("R5", 16'h5A5A);
      quiet("R5", 1);
      enter("R4", 16'hA5A5);
      quiet("R4", 1);
      cyc("R7", 0,1,0,0,0, '0,'0, 0,0,'0);
      take("R8");

      // R3: cancel in card-present
      insert("R3", 16'h0F0F);
      cyc("R3", 0,1,0,0,0, '0,'0, 0,0,'0);
      quiet("R8", 1);
      take("R8");

      // R12: validate together with cancel loads nothing and ejects
      insert("R12", 16'h7777);
      cyc("R12", 0,1,1,0,0, '0,16'h7777, 0,0,'0);
      take("R12");

      // R10, R11: corrupt the expected code while granted
      insert("R10", 16'h4242);
      enter("R10", 16'h4242);
      quiet("R10", 1);
      cyc("R10", 0,0,0,0,0, '0,'0, 1,1,16'h0010);
      quiet("R11", 1);
      quiet("R11", 1);
      take("R10");
      quiet("R10", 1);

      // R10: zero mask and select 3 have no effect
      cyc("R10", 0,0,0,0,0, '0,'0, 1,1,16'h0000);
      cyc("R10", 0,0,0,0,0, '0,'0, 1,3,16'hFFFF);
      quiet("R10", 2);

      // R10, R2: corrupt the counter in idle, insertion reloads it
      cyc("R10", 0,0,0,0,0, '0,'0, 1,0,16'h0002);
      quiet("R10", 2);
      insert("R2", 16'h1111);
      quiet("R10", 1);
      cyc("R3", 0,1,0,0,0, '0,'0, 0,0,'0);
      take("R8");

      // R11: entered code corrupted in the same cycle it loads
      insert("R11", 16'h2468);
      cyc("R11", 0,0,1,0,0, '0,16'h2468, 1,2,16'h8000);
      quiet("R11", 1);
      take("R11");
      quiet("R9", 2);

      // R11: error during card-present forces eject
      insert("R11", 16'h1357);
      cyc("R11", 0,0,0,0,0, '0,'0, 1,1,16'h0001);
      quiet("R11", 1);
      take("R11");
      quiet("R11", 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule